// File: doc/BRIEF.md
# Cartridge Backup Memory Decoder

This block watches a 24-bit CPU address bus and decides, for every access that falls inside a backup-memory window, whether the access is aimed at a parallel battery-backed RAM or at a serial EEPROM pin interface. A header parser sets up the window and memory type when a new image is announced. It takes a two-byte signature, the memory-kind flag bit and the start and end addresses, all pre-parsed outside the block. If the header is absent, the block opens a default window. It then infers the memory type from the first write that the software issues into that window.

A small set of status flags records whether the type is known, whether the window is an EEPROM, whether reads are enabled and whether RAM writes are blocked. Software changes enable and write-protect through a byte-wide control location. RAM accesses leave the block on a chip-select and write-enable port with a window-relative address. EEPROM accesses leave on their own strobe, together with the low address bit that selects the serial line. Bus cycles that the block does not claim raise a pass-through signal so that another responder can serve them.

Top module: `bkm_decoder`

## Requirements
- R1: With `hdr_sig` = 16'h4152 and `hdr_mem_kind` = 1 (bit 6 of the header flags byte), a load gives EEPROM mode, detected = 1, window low = `hdr_start` with bit 0 cleared, window high = `hdr_end`, and `win_bytes` = 8192.
- R2: With `hdr_sig` = 16'h4152 and `hdr_mem_kind` = 0, a load gives RAM mode with detected = 1. Window low is `hdr_start` with bits 7:0 cleared, window high is `hdr_end` with bit 0 set, and `win_bytes` = high - low + 1.
- R3: With any other signature, a load gives the window 0x200000..0x203FFF (`win_bytes` = 16384), with detected = 0 and EEPROM mode = 0.
- R4: While detected = 0, a write inside the window to 0x200000 or 0x200001 sets EEPROM mode and narrows the window to 0x200000..0x200001. Any other in-window write selects RAM mode and is itself written to RAM. In both cases detected becomes 1.
- R5: A byte write (`bus_word` = 0) to 0xA130F1, outside the window, loads enable from data bit 0 and write-protect from data bit 1. It leaves detected, EEPROM mode and dirty unchanged.
- R6: `hdr_load` and `soft_rst` both clear write-protect. Each sets enable to 1 only when EEPROM mode is 0 and `rom_size` <= window low. `soft_rst` keeps detected, EEPROM mode, the window and dirty.
- R7: An in-window read is served when enable or EEPROM mode is 1. It reads RAM (`ram_cs`) in RAM mode and the EEPROM (`ee_stb`, `ee_we` = 0) in EEPROM mode. A word read returns the byte in both halves, and a byte read returns it in bits 7:0 with bits 15:8 zero.
- R8: An access outside the window (other than the control write), or an in-window read that is not served, raises `pass_through`. It gives `rd_data` = 0 and raises neither `ram_cs` nor `ee_stb`.
- R9: A RAM write (`ram_we`) happens only for an in-window write in RAM mode with write-protect 0. It uses `ram_addr` = address - window low and sets dirty. A write-protected write changes neither the RAM nor dirty.
- R10: In EEPROM mode, an in-window write raises `ee_stb` with `ee_we` = 1 and never `ram_cs`.
- R11: After `rst_n` the window is 0x200000..0x203FFF and detected, EEPROM mode, enable, write-protect and dirty are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hdr_load | input | 1 | Apply the header inputs (new image) |
| hdr_sig | input | 16 | Signature bytes, first byte in bits 15:8 |
| hdr_mem_kind | input | 1 | Header flag: 1 = EEPROM |
| hdr_start | input | 24 | Header start address |
| hdr_end | input | 24 | Header end address |
| rom_size | input | 24 | Image size in bytes |
| soft_rst | input | 1 | System reset of the flags |
| bus_valid | input | 1 | Bus access in this cycle |
| bus_write | input | 1 | 1 = write |
| bus_word | input | 1 | 1 = 16-bit access |
| bus_addr | input | 24 | Byte address |
| bus_wdata | input | 8 | Write byte |
| rd_data | output | 16 | Read data |
| rd_hit | output | 1 | Read served here |
| pass_through | output | 1 | Access not claimed |
| ram_cs | output | 1 | RAM select |
| ram_we | output | 1 | RAM write enable |
| ram_addr | output | 16 | Window-relative RAM address |
| ram_wdata | output | 8 | RAM write byte |
| ram_rdata | input | 8 | RAM read byte |
| ee_stb | output | 1 | EEPROM access strobe |
| ee_we | output | 1 | EEPROM write |
| ee_lsb | output | 1 | Address bit 0 of the EEPROM access |
| ee_wdata | output | 8 | EEPROM write byte |
| ee_rdata | input | 8 | EEPROM read byte |
| win_lo | output | 24 | Window low address |
| win_hi | output | 24 | Window high address |
| win_bytes | output | 24 | Backing storage size |
| st_det | output | 1 | Type detected |
| st_ee | output | 1 | EEPROM mode |
| st_en | output | 1 | Read enable |
| st_wp | output | 1 | Write-protect |
| dirty | output | 1 | A RAM write has completed |

## Verification
A wrong window register shows up at `win_lo`/`win_hi` in the cycle after the load. It also shows in the next access: `pass_through` or the wrong `ram_addr` then appears in the same combinational cycle. A stale EEPROM or detected flag steers the next in-window write to the wrong strobe at once. Because of this, every cycle compares strobes, addresses and read data against a behavioural model. Enable and write-protect errors surface on the first read or write that follows a control write or reset.

// File: rtl/bkm_pkg.sv
package bkm_pkg;
  localparam int unsigned BKM_AW = 24;
  localparam logic [23:0] DEF_LO    = 24'h200000;
  localparam logic [23:0] DEF_HI    = 24'h203FFF;
  localparam logic [23:0] CTRL_ADDR = 24'hA130F1;
  localparam logic [23:0] PROBE_LO  = 24'h200000;
  localparam logic [23:0] EE_BYTES  = 24'h002000;
  localparam logic [15:0] HDR_MAGIC = 16'h4152;

  typedef struct packed {
    logic det;
    logic ee;
    logic en;
    logic wp;
  } bkm_flags_t;
endpackage

// File: rtl/bkm_hdr.sv
module bkm_hdr
  import bkm_pkg::*;
#(
  parameter int unsigned ADDR_W = BKM_AW
) (
  input  logic [15:0]       sig,
  input  logic              kind_ee,
  input  logic [ADDR_W-1:0] start_a,
  input  logic [ADDR_W-1:0] end_a,
  output logic [ADDR_W-1:0] lo,
  output logic [ADDR_W-1:0] hi,
  output logic              det,
  output logic              ee
);
  logic sig_ok;
  assign sig_ok = (sig == HDR_MAGIC);

  always_comb begin
    lo  = ADDR_W'(DEF_LO);
    hi  = ADDR_W'(DEF_HI);
    det = 1'b0;
    ee  = 1'b0;
    if (sig_ok) begin
      det = 1'b1;
      if (kind_ee) begin
        ee = 1'b1;
        lo = {start_a[ADDR_W-1:1], 1'b0};
        hi = end_a;
      end else begin
        lo = {start_a[ADDR_W-1:8], 8'h00};
        hi = {end_a[ADDR_W-1:1], 1'b1};
      end
    end
  end
endmodule

// File: rtl/bkm_access.sv
module bkm_access
  import bkm_pkg::*;
#(
  parameter int unsigned ADDR_W = BKM_AW,
  parameter int unsigned RAM_AW = 16
) (
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic [ADDR_W-1:0] win_lo,
  input  logic [ADDR_W-1:0] win_hi,
  input  bkm_flags_t        flags,
  input  logic [7:0]        ram_rdata,
  input  logic [7:0]        ee_rdata,
  output logic              det_wr,
  output logic              ee_pick,
  output logic              ctrl_wr,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              ee_stb,
  output logic              ee_we,
  output logic              ee_lsb,
  output logic [7:0]        ee_wdata,
  output logic              rd_hit,
  output logic [15:0]       rd_data,
  output logic              pass_through
);
  logic in_win, wr_in, rd_svc, mode_ee;
  logic [7:0] rbyte;

  assign in_win  = bus_valid && (bus_addr >= win_lo) && (bus_addr <= win_hi);
  assign wr_in   = in_win && bus_write;
  assign ctrl_wr = bus_valid && bus_write && !bus_word && !in_win
                   && (bus_addr == ADDR_W'(CTRL_ADDR));
  assign det_wr  = wr_in && !flags.det;
  assign ee_pick = det_wr && (bus_addr[ADDR_W-1:1] == PROBE_LO[ADDR_W-1:1]);
  assign mode_ee = flags.ee || ee_pick;
  assign rd_svc  = in_win && !bus_write && (flags.en || flags.ee);

  assign ram_we    = wr_in && !mode_ee && !flags.wp;
  assign ram_cs    = ram_we || (rd_svc && !flags.ee);
  assign ram_addr  = RAM_AW'(bus_addr - win_lo);
  assign ram_wdata = bus_wdata;

  assign ee_stb   = (wr_in && mode_ee) || (rd_svc && flags.ee);
  assign ee_we    = wr_in;
  assign ee_lsb   = bus_addr[0];
  assign ee_wdata = bus_wdata;

  assign rbyte  = flags.ee ? ee_rdata : ram_rdata;
  assign rd_hit = rd_svc;

  always_comb begin
    rd_data = 16'h0000;
    if (rd_svc) rd_data = bus_word ? {rbyte, rbyte} : {8'h00, rbyte};
  end

  assign pass_through = (bus_valid && !in_win && !ctrl_wr)
                        || (in_win && !bus_write && !rd_svc);
endmodule

// File: rtl/bkm_regs.sv
module bkm_regs
  import bkm_pkg::*;
#(
  parameter int unsigned ADDR_W = BKM_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_load,
  input  logic [ADDR_W-1:0] h_lo,
  input  logic [ADDR_W-1:0] h_hi,
  input  logic              h_det,
  input  logic              h_ee,
  input  logic [ADDR_W-1:0] rom_size,
  input  logic              soft_rst,
  input  logic              det_wr,
  input  logic              ee_pick,
  input  logic              ctrl_wr,
  input  logic [1:0]        ctrl_bits,
  input  logic              ram_wr,
  output logic [ADDR_W-1:0] lo_q,
  output logic [ADDR_W-1:0] hi_q,
  output bkm_flags_t        flags_q,
  output logic              dirty_q
);
  logic [ADDR_W-1:0] lo_d, hi_d;
  bkm_flags_t        flags_d;
  logic              dirty_d, upd;

  assign upd = hdr_load || soft_rst || det_wr || ctrl_wr || ram_wr;

  always_comb begin
    lo_d    = lo_q;
    hi_d    = hi_q;
    flags_d = flags_q;
    dirty_d = dirty_q;
    if (hdr_load) begin
      lo_d        = h_lo;
      hi_d        = h_hi;
      flags_d.det = h_det;
      flags_d.ee  = h_ee;
      flags_d.en  = !h_ee && (rom_size <= h_lo);
      flags_d.wp  = 1'b0;
      dirty_d     = 1'b0;
    end else if (soft_rst) begin
      flags_d.en = !flags_q.ee && (rom_size <= lo_q);
      flags_d.wp = 1'b0;
    end else begin
      if (det_wr) flags_d.det = 1'b1;
      if (ee_pick) begin
        flags_d.ee = 1'b1;
        lo_d       = ADDR_W'(PROBE_LO);
        hi_d       = ADDR_W'(PROBE_LO) | ADDR_W'(1);
      end
      if (ctrl_wr) begin
        flags_d.en = ctrl_bits[0];
        flags_d.wp = ctrl_bits[1];
      end
      if (ram_wr) dirty_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_q    <= ADDR_W'(DEF_LO);
      hi_q    <= ADDR_W'(DEF_HI);
      flags_q <= '0;
      dirty_q <= 1'b0;
    end else if (upd) begin
      lo_q    <= lo_d;
      hi_q    <= hi_d;
      flags_q <= flags_d;
      dirty_q <= dirty_d;
    end
  end
endmodule

// File: rtl/bkm_decoder.sv
module bkm_decoder
  import bkm_pkg::*;
#(
  parameter int unsigned ADDR_W = BKM_AW,
  parameter int unsigned RAM_AW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hdr_load,
  input  logic [15:0]       hdr_sig,
  input  logic              hdr_mem_kind,
  input  logic [ADDR_W-1:0] hdr_start,
  input  logic [ADDR_W-1:0] hdr_end,
  input  logic [ADDR_W-1:0] rom_size,
  input  logic              soft_rst,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic              bus_word,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [15:0]       rd_data,
  output logic              rd_hit,
  output logic              pass_through,
  output logic              ram_cs,
  output logic              ram_we,
  output logic [RAM_AW-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              ee_stb,
  output logic              ee_we,
  output logic              ee_lsb,
  output logic [7:0]        ee_wdata,
  input  logic [7:0]        ee_rdata,
  output logic [ADDR_W-1:0] win_lo,
  output logic [ADDR_W-1:0] win_hi,
  output logic [ADDR_W-1:0] win_bytes,
  output logic              st_det,
  output logic              st_ee,
  output logic              st_en,
  output logic              st_wp,
  output logic              dirty
);
  logic [ADDR_W-1:0] h_lo, h_hi;
  logic              h_det, h_ee;
  logic              det_wr, ee_pick, ctrl_wr;
  bkm_flags_t        flags;

  bkm_hdr #(.ADDR_W(ADDR_W)) u_hdr (
    .sig(hdr_sig), .kind_ee(hdr_mem_kind), .start_a(hdr_start), .end_a(hdr_end),
    .lo(h_lo), .hi(h_hi), .det(h_det), .ee(h_ee)
  );

  bkm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .hdr_load(hdr_load),
    .h_lo(h_lo), .h_hi(h_hi), .h_det(h_det), .h_ee(h_ee),
    .rom_size(rom_size), .soft_rst(soft_rst),
    .det_wr(det_wr), .ee_pick(ee_pick), .ctrl_wr(ctrl_wr),
    .ctrl_bits(bus_wdata[1:0]), .ram_wr(ram_we),
    .lo_q(win_lo), .hi_q(win_hi), .flags_q(flags), .dirty_q(dirty)
  );

  bkm_access #(.ADDR_W(ADDR_W), .RAM_AW(RAM_AW)) u_acc (
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_word(bus_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .win_lo(win_lo), .win_hi(win_hi), .flags(flags),
    .ram_rdata(ram_rdata), .ee_rdata(ee_rdata),
    .det_wr(det_wr), .ee_pick(ee_pick), .ctrl_wr(ctrl_wr),
    .ram_cs(ram_cs), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
    .ee_stb(ee_stb), .ee_we(ee_we), .ee_lsb(ee_lsb), .ee_wdata(ee_wdata),
    .rd_hit(rd_hit), .rd_data(rd_data), .pass_through(pass_through)
  );

  assign st_det    = flags.det;
  assign st_ee     = flags.ee;
  assign st_en     = flags.en;
  assign st_wp     = flags.wp;
  assign win_bytes = flags.ee ? ADDR_W'(EE_BYTES) : (win_hi - win_lo + ADDR_W'(1));
endmodule

// File: rtl/bkm_checker.sv
module bkm_checker
  import bkm_pkg::*;
#(
  parameter int unsigned ADDR_W = BKM_AW
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hdr_load,
  input logic              soft_rst,
  input logic              bus_valid,
  input logic              bus_write,
  input logic              bus_word,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic [ADDR_W-1:0] win_lo,
  input logic [ADDR_W-1:0] win_hi,
  input logic              st_det,
  input logic              st_ee,
  input logic              st_en,
  input logic              st_wp,
  input logic              dirty,
  input logic              ram_cs,
  input logic              ram_we,
  input logic              ee_stb,
  input logic [15:0]       rd_data,
  input logic              rd_hit,
  input logic              pass_through
);
  logic ctrl_acc, quiet;
  assign quiet    = !hdr_load && !soft_rst;
  assign ctrl_acc = bus_valid && bus_write && !bus_word && (bus_addr == ADDR_W'(CTRL_ADDR))
                    && !((bus_addr >= win_lo) && (bus_addr <= win_hi)) && quiet;

  a_r9_ram_write_gate: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (!st_wp && !st_ee));

  a_r9_dirty_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && quiet) |=> dirty);

  a_r8_pass_is_silent: assert property (@(posedge clk) disable iff (!rst_n)
    pass_through |-> (!ram_cs && !ee_stb && !rd_hit && rd_data == 16'h0000));

  a_r7_word_duplicated: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_hit && bus_word) |-> (rd_data[15:8] == rd_data[7:0]));

  a_r4_detect_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (st_det && !hdr_load) |=> st_det);

  a_r5_ctrl_load: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_acc |=> (st_en == $past(bus_wdata[0]) && st_wp == $past(bus_wdata[1])
                  && st_det == $past(st_det) && st_ee == $past(st_ee)));

  a_r10_ee_excludes_ram: assert property (@(posedge clk) disable iff (!rst_n)
    st_ee |-> !ram_cs);

  a_r6_reset_clears_wp: assert property (@(posedge clk) disable iff (!rst_n)
    (soft_rst || hdr_load) |=> !st_wp);
endmodule

bind bkm_decoder bkm_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/test_bkm_decoder.sv
module test_bkm_decoder;
  localparam int AW = 24;
  localparam int RAW = 16;

  logic clk = 1'b0;
  logic rst_n;
  always #5 clk = ~clk;

  logic hdr_load, hdr_mem_kind, soft_rst;
  logic [15:0] hdr_sig;
  logic [AW-1:0] hdr_start, hdr_end, rom_size;
  logic bus_valid, bus_write, bus_word;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [15:0] rd_data;
  logic rd_hit, pass_through, ram_cs, ram_we, ee_stb, ee_we, ee_lsb;
  logic [RAW-1:0] ram_addr;
  logic [7:0] ram_wdata, ram_rdata, ee_wdata, ee_rdata;
  logic [AW-1:0] win_lo, win_hi, win_bytes;
  logic st_det, st_ee, st_en, st_wp, dirty;

  bkm_decoder i_bkm_decoder (
    .clk(clk), .rst_n(rst_n), .hdr_load(hdr_load), .hdr_sig(hdr_sig),
    .hdr_mem_kind(hdr_mem_kind), .hdr_start(hdr_start), .hdr_end(hdr_end),
    .rom_size(rom_size), .soft_rst(soft_rst), .bus_valid(bus_valid),
    .bus_write(bus_write), .bus_word(bus_word), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .rd_data(rd_data), .rd_hit(rd_hit),
    .pass_through(pass_through), .ram_cs(ram_cs), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .ee_stb(ee_stb), .ee_we(ee_we), .ee_lsb(ee_lsb), .ee_wdata(ee_wdata),
    .ee_rdata(ee_rdata), .win_lo(win_lo), .win_hi(win_hi), .win_bytes(win_bytes),
    .st_det(st_det), .st_ee(st_ee), .st_en(st_en), .st_wp(st_wp), .dirty(dirty)
  );

  // external RAM and EEPROM models
  logic [7:0] mem [0:255];
  always @(posedge clk) if (ram_we) mem[ram_addr[7:0]] <= ram_wdata;
  assign ram_rdata = mem[ram_addr[7:0]];
  assign ee_rdata  = 8'hC3 ^ {7'b0, ee_lsb};

  // behavioural reference state
  int m_lo, m_hi;
  bit m_det, m_ee, m_en, m_wp, m_dirty;
  byte unsigned ref_mem [256];
  int vecs = 0, bad = 0;
  bit done = 0;

  task automatic chk(string tag, string nm, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, nm, act, exp);
    end
  endtask

  function automatic bit f_in_win();
    int a = int'(bus_addr);
    return bus_valid && a >= m_lo && a <= m_hi;
  endfunction

  task automatic compare(string tag);
    int a = int'(bus_addr);
    bit in_win = f_in_win();
    bit ctrl = bus_valid && bus_write && !bus_word && a == 32'hA130F1 && !in_win;
    bit pick = in_win && bus_write && !m_det && (a == 32'h200000 || a == 32'h200001);
    bit mee  = m_ee || pick;
    bit svc  = in_win && !bus_write && (m_en || m_ee);
    bit e_ee = (in_win && bus_write && mee) || (svc && m_ee);
    bit e_we = in_win && bus_write && !mee && !m_wp;
    bit e_cs = e_we || (svc && !m_ee);
    bit e_pt = (bus_valid && !in_win && !ctrl) || (in_win && !bus_write && !svc);
    logic [7:0] b;
    logic [15:0] e_rd;
    b = m_ee ? (8'hC3 ^ {7'b0, bus_addr[0]}) : ref_mem[(a - m_lo) & 255];
    e_rd = !svc ? 16'h0 : (bus_word ? {b, b} : {8'h00, b});
    chk(tag, "win_lo", win_lo, m_lo);
    chk(tag, "win_hi", win_hi, m_hi);
    chk(tag, "win_bytes", win_bytes, m_ee ? 8192 : m_hi - m_lo + 1);
    chk(tag, "flags", {st_det, st_ee, st_en, st_wp}, {m_det, m_ee, m_en, m_wp});
    chk(tag, "dirty", dirty, m_dirty);
    chk(tag, "ram_cs", ram_cs, e_cs);
    chk(tag, "ram_we", ram_we, e_we);
    chk(tag, "ee_stb", ee_stb, e_ee);
    chk(tag, "pass_through", pass_through, e_pt);
    chk(tag, "rd_hit", rd_hit, svc);
    chk(tag, "rd_data", rd_data, e_rd);
    if (e_cs) chk(tag, "ram_addr", ram_addr, (a - m_lo) & 16'hFFFF);
    if (e_ee) chk(tag, "ee_we", ee_we, bus_write);
  endtask

  task automatic update();
    int a = int'(bus_addr);
    bit in_win = f_in_win();
    if (hdr_load) begin
      if (hdr_sig == 16'h4152) begin
        m_det = 1;
        m_ee  = hdr_mem_kind;
        m_lo  = hdr_mem_kind ? (int'(hdr_start) & ~1) : (int'(hdr_start) & ~255);
        m_hi  = hdr_mem_kind ? int'(hdr_end) : (int'(hdr_end) | 1);
      end else begin
        m_det = 0; m_ee = 0; m_lo = 32'h200000; m_hi = 32'h203FFF;
      end
      m_en = !m_ee && int'(rom_size) <= m_lo;
      m_wp = 0; m_dirty = 0;
    end else if (soft_rst) begin
      m_en = !m_ee && int'(rom_size) <= m_lo;
      m_wp = 0;
    end else begin
      bit pick = in_win && bus_write && !m_det && (a == 32'h200000 || a == 32'h200001);
      bit ctrl = bus_valid && bus_write && !bus_word && a == 32'hA130F1 && !in_win;
      bit we   = in_win && bus_write && !(m_ee || pick) && !m_wp;
      if (we) begin
        ref_mem[(a - m_lo) & 255] = bus_wdata;
        m_dirty = 1;
      end
      if (in_win && bus_write && !m_det) m_det = 1;
      if (pick) begin m_ee = 1; m_lo = 32'h200000; m_hi = 32'h200001; end
      if (ctrl) begin m_en = bus_wdata[0]; m_wp = bus_wdata[1]; end
    end
  endtask

  task automatic step(string tag);
    #1 compare(tag);
    @(posedge clk);
    update();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_valid = 0; bus_write = 0; bus_word = 0; bus_addr = '0; bus_wdata = '0;
    hdr_load = 0; soft_rst = 0;
  endtask

  task automatic rd(string tag, int a, bit w);
    bus_valid = 1; bus_write = 0; bus_word = w; bus_addr = AW'(a);
    step(tag); idle();
  endtask

  task automatic wr(string tag, int a, logic [7:0] d);
    bus_valid = 1; bus_write = 1; bus_word = 0; bus_addr = AW'(a); bus_wdata = d;
    step(tag); idle();
  endtask

  task automatic hdr(string tag, logic [15:0] s, bit k, int st, int en, int rom);
    hdr_sig = s; hdr_mem_kind = k; hdr_start = AW'(st); hdr_end = AW'(en);
    rom_size = AW'(rom); hdr_load = 1;
    step(tag); idle();
    step(tag);
  endtask

  task automatic srst(string tag);
    soft_rst = 1; step(tag); idle(); step(tag);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end

  initial begin
    idle();
    hdr_sig = '0; hdr_mem_kind = 0; hdr_start = '0; hdr_end = '0; rom_size = '0;
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i) ^ 8'hA5;
      ref_mem[i] = 8'(i) ^ 8'hA5;
    end
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_lo = 32'h200000; m_hi = 32'h203FFF;
    m_det = 0; m_ee = 0; m_en = 0; m_wp = 0; m_dirty = 0;
    step("R11");                                   // reset state
    hdr("R3", 16'h0000, 0, 0, 0, 32'h100000);      // no header: default window
    rd("R7", 32'h200010, 0);                       // byte read served
    rd("R7", 32'h200011, 1);                       // word read duplicated
    wr("R4", 32'h200004, 8'h3C);                   // pending: RAM inferred
    step("R4");
    rd("R7", 32'h200004, 1);
    rd("R8", 32'h100000, 0);                       // outside window
    wr("R8", 32'h204000, 8'h11);
    wr("R5", 32'hA130F1, 8'h02);                   // enable off, protect on
    step("R5");
    rd("R8", 32'h200004, 0);                       // read not served
    wr("R9", 32'h200004, 8'h99);                   // protected write ignored
    srst("R6");                                    // wp cleared, enable back
    rd("R9", 32'h200004, 0);                       // still 3C
    hdr("R2", 16'h4152, 0, 32'h200123, 32'h2001FE, 32'h300000);
    rd("R8", 32'h200150, 0);                       // ROM overlaps: disabled
    wr("R5", 32'hA130F1, 8'h01);
    step("R5");
    rd("R7", 32'h200150, 1);
    wr("R9", 32'h2001FF, 8'h77);
    step("R9");
    rd("R9", 32'h2001FF, 0);
    wr("R8", 32'h200200, 8'h12);
    hdr("R1", 16'h4152, 1, 32'h200001, 32'h200001, 32'h100000);
    rd("R7", 32'h200001, 0);                       // EEPROM read
    rd("R7", 32'h200000, 1);
    wr("R10", 32'h200000, 8'h01);                  // EEPROM write
    step("R10");
    hdr("R3", 16'h4153, 0, 32'h300000, 32'h300FFF, 32'h100000);
    wr("R4", 32'h200001, 8'h80);                   // pending: EEPROM inferred
    step("R4");
    rd("R8", 32'h200002, 0);                       // window narrowed
    srst("R6");                                    // EEPROM keeps enable low
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule